// File: doc/BRIEF.md
# Elapsed-Time Counter with Alarm

This block keeps running time as four cascaded counts (seconds, minutes, hours and a plain sixteen-bit count of elapsed days) driven by a one-second tick. The tick is made from the input reference clock by a seven-bit prescaler followed by a sixteen-bit scaler, so the block can run from a wide range of reference frequencies. Software sets the starting time, so no epoch is assumed. It reads the time back at any moment, programs an alarm time and turns the alarm interrupt on or off.

When the counted time becomes equal to the programmed alarm time in all four fields, a sticky alarm flag is set. The flag is gated by the alarm enable and drives both an interrupt line and a wake line, which pulls the device out of a low-power state. The only reset is the power-on input, so any other chip reset leaves the time running. A read of the seconds register captures all four counts at once, so a carry that lands between reads cannot return a torn time.

Register map (4-bit address, 16-bit data): 0 control (bit 0 alarm enable), 1 status (bit 0 alarm flag, write 1 to clear), 2 prescale reload (7 bits), 3 scale reload (16 bits), 4 seconds, 5 minutes, 6 hours, 7 days, 8 alarm seconds, 9 alarm minutes, 10 alarm hours, 11 alarm days. Unused addresses read as 0.

Top module: `tod_timer`

## Requirements
- R1: While `por` is high at a clock edge, all counts, alarm fields, the enable and the flag clear to 0, the prescale reload becomes 127 and the scale reload becomes 0xFFFF, and `irq` and `wake` are 0.
- R2: With prescale reload P and scale reload S, the seconds count advances once every (P+1)*(S+1) clock cycles. Writing either reload restarts the divider, and the first advance comes (P+1)*(S+1)+1 cycles after that write edge.
- R3: Seconds and minutes step from 59 to 0 and carry into the next field on that step.
- R4: Hours step from 23 to 0 and carry into days.
- R5: Days step from 65535 to 0.
- R6: A write to any of addresses 4 to 7 loads that field, and any tick that falls in the same cycle is dropped for all fields.
- R7: `rd_data` holds the addressed register one cycle after `rd_en`. A read of address 4 returns live seconds and captures all four counts. Reads of addresses 5 to 7 return the values captured at that last seconds read.
- R8: The alarm flag (status bit 0) is set in the cycle after the four counts become equal to the four alarm fields, whatever the enable. It is not set while any field differs.
- R9: The flag stays set until a write to status with bit 0 = 1. A write with bit 0 = 0 leaves it set.
- R10: `irq` and `wake` are equal, and each is registered as flag AND enable, one cycle after either input changes.
- R11: Configuration and alarm registers read back as written, truncated to their width. The prescale keeps 7 bits and the control keeps bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Alarm interrupt |
| wake | output | 1 | Wake request from low power |

## Verification
The bench steps the counts one tick at a time across the seconds, minutes, hours and day roll-overs. A design that compared against the wrong limit, or forgot a carry, would show an hour or day that is off by one. It reads minutes after a carry that happened since the last seconds read. A block with no capture would return the newer minute there. It lands a time write on the same cycle as a tick: a design that let the tick through would show one second too many. It also sets the alarm with only some fields equal, clears the flag with a zero bit, and toggles the enable. A wrong match, a flag that is not sticky, or an ungated interrupt would each show up at the ports.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int NFIELD = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_PRESC = 4'd2;
  localparam logic [ADDR_W-1:0] A_SCALE = 4'd3;
  localparam logic [ADDR_W-1:0] A_TIME  = 4'd4;   // 4..7 sec, min, hour, day
  localparam logic [ADDR_W-1:0] A_ALARM = 4'd8;   // 8..11 same order

  // Highest value of each field before it returns to zero.
  function automatic logic [DATA_W-1:0] field_limit(input int idx);
    case (idx)
      0, 1:    return DATA_W'(59);
      2:       return DATA_W'(23);
      default: return {DATA_W{1'b1}};
    endcase
  endfunction

  typedef logic [NFIELD-1:0][DATA_W-1:0] tod_time_t;
endpackage

// File: rtl/tod_divider.sv
module tod_divider #(
  parameter int PW = 7,
  parameter int SW = 16,
  parameter logic [PW-1:0] P_RST = '1,
  parameter logic [SW-1:0] S_RST = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          p_wr,
  input  logic          s_wr,
  input  logic [SW-1:0] din,
  output logic [PW-1:0] p_reload,
  output logic [SW-1:0] s_reload,
  output logic          tick
);
  logic [PW-1:0] p_cnt;
  logic [SW-1:0] s_cnt;
  logic          cfg;

  assign cfg = p_wr | s_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_reload <= P_RST;
      s_reload <= S_RST;
      p_cnt    <= '0;
      s_cnt    <= '0;
      tick     <= 1'b0;
    end else begin
      if (p_wr) p_reload <= din[PW-1:0];
      if (s_wr) s_reload <= din;
      if (cfg) begin
        p_cnt <= '0;
        s_cnt <= '0;
        tick  <= 1'b0;
      end else if (p_cnt == p_reload) begin
        p_cnt <= '0;
        if (s_cnt == s_reload) begin
          s_cnt <= '0;
          tick  <= 1'b1;
        end else begin
          s_cnt <= s_cnt + 1'b1;
          tick  <= 1'b0;
        end
      end else begin
        p_cnt <= p_cnt + 1'b1;
        tick  <= 1'b0;
      end
    end
  end

  // R2: with a division ratio above one, ticks never come back to back
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !cfg && (p_reload != '0 || s_reload != '0)) |=> !tick);
  // R2: a reload write restarts the divider, so no tick follows it directly
  assert_cfg_restart_R2: assert property (@(posedge clk) disable iff (rst)
    cfg |=> !tick);
endmodule

// File: rtl/tod_stage.sv
module tod_stage #(
  parameter int W = 16,
  parameter logic [W-1:0] LIMIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] val,
  output logic         carry
);
  logic wrap;
  assign wrap  = (val >= LIMIT);
  assign carry = inc & wrap;

  always_ff @(posedge clk) begin
    if (rst)      val <= '0;
    else if (ld)  val <= ld_val;
    else if (inc) val <= wrap ? '0 : val + 1'b1;
  end

  // R3 / R4 / R5: a step at the field limit returns the field to zero
  assert_stage_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && val == LIMIT) |=> (val == '0));
  // R6: without a step or a load the field holds
  assert_stage_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!inc && !ld) |=> $stable(val));
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  tod_time_t now,
  input  tod_time_t target,
  input  logic      en,
  input  logic      clr,
  output logic      flag,
  output logic      irq,
  output logic      wake
);
  logic match, match_q;
  assign match = (now == target);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b1;
      flag    <= 1'b0;
      irq     <= 1'b0;
      wake    <= 1'b0;
    end else begin
      match_q <= match;
      if (match && !match_q) flag <= 1'b1;
      else if (clr)          flag <= 1'b0;
      irq  <= flag & en;
      wake <= flag & en;
    end
  end

  // R9: without a clear the flag stays set
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  // R8: the flag only rises on a fresh match
  assert_flag_cause_R8: assert property (@(posedge clk) disable iff (rst)
    (!flag && !(match && !match_q)) |=> !flag);
  // R10: with the enable off the interrupt stays low
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq);
  // R10: wake mirrors the interrupt
  assert_wake_equal_R10: assert property (@(posedge clk) disable iff (rst)
    wake == irq);
endmodule

// File: rtl/tod_timer.sv
module tod_timer
  import tod_pkg::*;
#(
  parameter int PRESC_W = 7,
  parameter int SCALE_W = 16,
  parameter logic [PRESC_W-1:0] PRESC_RST = '1,
  parameter logic [SCALE_W-1:0] SCALE_RST = '1
) (
  input  logic              clk,
  input  logic              por,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              wake
);
  localparam int FW = $clog2(NFIELD);

  logic [PRESC_W-1:0] p_reload;
  logic [SCALE_W-1:0] s_reload;
  logic               tick, step;
  logic               alarm_en, flag;
  tod_time_t          now, target, snap;
  logic [NFIELD-1:0]  t_ld, a_ld;
  logic [NFIELD:0]    chain;

  tod_divider #(.PW(PRESC_W), .SW(SCALE_W), .P_RST(PRESC_RST), .S_RST(SCALE_RST)) u_div (
    .clk(clk), .rst(por),
    .p_wr(wr_en && wr_addr == A_PRESC),
    .s_wr(wr_en && wr_addr == A_SCALE),
    .din(wr_data[SCALE_W-1:0]),
    .p_reload(p_reload), .s_reload(s_reload), .tick(tick));

  assign step     = tick & ~|t_ld;
  assign chain[0] = step;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    assign t_ld[i] = wr_en && wr_addr == A_TIME + ADDR_W'(i);
    assign a_ld[i] = wr_en && wr_addr == A_ALARM + ADDR_W'(i);

    tod_stage #(.W(DATA_W), .LIMIT(field_limit(i))) u_stage (
      .clk(clk), .rst(por), .inc(chain[i]), .ld(t_ld[i]),
      .ld_val(wr_data), .val(now[i]), .carry(chain[i+1]));

    always_ff @(posedge clk) begin
      if (por)          target[i] <= '0;
      else if (a_ld[i]) target[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (por)                           alarm_en <= 1'b0;
    else if (wr_en && wr_addr == A_CTRL) alarm_en <= wr_data[0];
  end

  tod_alarm u_alarm (
    .clk(clk), .rst(por), .now(now), .target(target), .en(alarm_en),
    .clr(wr_en && wr_addr == A_STAT && wr_data[0]),
    .flag(flag), .irq(irq), .wake(wake));

  // Read port: a seconds read captures all four fields.
  always_ff @(posedge clk) begin
    if (por) begin
      rd_data <= '0;
      snap    <= '0;
    end else if (rd_en) begin
      if (rd_addr == A_TIME) snap <= now;
      if (rd_addr == A_CTRL)       rd_data <= DATA_W'(alarm_en);
      else if (rd_addr == A_STAT)  rd_data <= DATA_W'(flag);
      else if (rd_addr == A_PRESC) rd_data <= DATA_W'(p_reload);
      else if (rd_addr == A_SCALE) rd_data <= DATA_W'(s_reload);
      else if (rd_addr == A_TIME)  rd_data <= now[0];
      else if (rd_addr > A_TIME && rd_addr < A_ALARM)
        rd_data <= snap[rd_addr[FW-1:0]];
      else if (rd_addr >= A_ALARM && rd_addr < A_ALARM + ADDR_W'(NFIELD))
        rd_data <= target[rd_addr[FW-1:0]];
      else rd_data <= '0;
    end
  end

  // R7: between seconds reads the captured fields do not move
  assert_snap_stable_R7: assert property (@(posedge clk) disable iff (por)
    !(rd_en && rd_addr == A_TIME) |=> $stable(snap));
  // R6: a time write drops a tick that lands on the same cycle
  assert_write_drops_tick_R6: assert property (@(posedge clk) disable iff (por)
    (tick && t_ld[0] == 1'b0 && t_ld[1]) |=> $stable(now[0]));
endmodule

// File: tb/tod_timer_tb.sv
module tod_timer_tb;
  logic        clk = 1'b0;
  logic        por = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq, wake;
  int checks = 0, errors = 0;
  logic [15:0] v;

  always #4 clk = ~clk;   // 125 MHz

  tod_timer u_dut (.clk(clk), .por(por), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .wake(wake));

  // {address, write data, expected read}
  localparam logic [35:0] VEC [8] = '{
    {4'd2,  16'h01FF, 16'h007F},
    {4'd3,  16'h1234, 16'h1234},
    {4'd8,  16'h0025, 16'h0025},
    {4'd11, 16'hBEEF, 16'hBEEF},
    {4'd0,  16'h0003, 16'h0001},
    {4'd0,  16'h0000, 16'h0000},
    {4'd4,  16'h002A, 16'h002A},
    {4'd14, 16'h5555, 16'h0000}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic load(input logic [15:0] s, input logic [15:0] m,
                      input logic [15:0] h, input logic [15:0] dd);
    wr(4'd4, s); wr(4'd5, m); wr(4'd6, h); wr(4'd7, dd);
  endtask

  // exactly one tick with the prescale reload at 0
  task automatic step1();
    wr(4'd3, 16'h0000);
    @(negedge clk);
    wr(4'd3, 16'hFFFF);
  endtask

  task automatic expect_time(input string tag, input logic [15:0] s, input logic [15:0] m,
                             input logic [15:0] h, input logic [15:0] dd);
    logic [15:0] r;
    rd(4'd4, r); chk(tag, r, s);
    rd(4'd5, r); chk(tag, r, m);
    rd(4'd6, r); chk(tag, r, h);
    rd(4'd7, r); chk(tag, r, dd);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 wake", {15'd0, wake}, 16'd0);
    expect_time("R1 time", 0, 0, 0, 0);
    rd(4'd1, v); chk("R1 flag", v, 16'd0);
    rd(4'd2, v); chk("R1 prescale", v, 16'h007F);
    rd(4'd3, v); chk("R1 scale", v, 16'hFFFF);
    rd(4'd11, v); chk("R1 alarm day", v, 16'd0);

    // R11 register readback walk
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][35:32], VEC[i][31:16]);
      rd(VEC[i][35:32], v);
      chk("R11 readback", v, VEC[i][15:0]);
    end

    // freeze: prescale 0, scale max
    wr(4'd2, 16'h0000);
    wr(4'd3, 16'hFFFF);
    for (int i = 8; i < 12; i++) wr(4'(i), 16'h0100);

    // R2 tick period with P=1 S=2 -> 6 cycles
    load(0, 0, 0, 0);
    wr(4'd2, 16'h0001);
    wr(4'd3, 16'h0002);
    repeat (6) @(negedge clk);
    rd(4'd4, v); chk("R2 before first tick", v, 16'd0);
    rd(4'd4, v); chk("R2 first tick", v, 16'd1);
    repeat (4) @(negedge clk);
    rd(4'd4, v); chk("R2 before second tick", v, 16'd1);
    rd(4'd4, v); chk("R2 second tick", v, 16'd2);
    wr(4'd2, 16'h0000);
    wr(4'd3, 16'hFFFF);

    // R7 capture, R3 seconds carry
    load(59, 7, 3, 9);
    rd(4'd4, v); chk("R7 live seconds", v, 16'd59);
    step1();
    rd(4'd5, v); chk("R7 captured minutes", v, 16'd7);
    expect_time("R3 seconds carry", 0, 8, 3, 9);

    // R3 minutes carry
    load(59, 59, 5, 0);
    step1();
    expect_time("R3 minutes carry", 0, 0, 6, 0);

    // R4 hours carry into days
    load(59, 59, 23, 41);
    step1();
    expect_time("R4 hours carry", 0, 0, 0, 42);

    // R5 day wrap
    load(59, 59, 23, 16'hFFFF);
    step1();
    expect_time("R5 day wrap", 0, 0, 0, 0);

    // R6 a time write on a tick cycle drops the tick
    load(0, 0, 0, 0);
    wr(4'd3, 16'h0000);
    @(negedge clk);
    wr(4'd5, 16'd20);
    wr(4'd3, 16'hFFFF);
    expect_time("R6 tick dropped", 1, 20, 0, 0);

    // R8 alarm match
    for (int i = 8; i < 12; i++) wr(4'(i), 16'h0000);
    wr(4'd8, 16'd5); wr(4'd9, 16'd1);
    load(4, 0, 0, 0);
    wr(4'd1, 16'h0001);
    step1();
    repeat (2) @(negedge clk);
    rd(4'd1, v); chk("R8 partial match no flag", v, 16'd0);
    wr(4'd4, 16'd4); wr(4'd5, 16'd1);
    step1();
    repeat (2) @(negedge clk);
    rd(4'd1, v); chk("R8 full match sets flag", v, 16'd1);
    // R10 gated by enable
    chk("R10 irq off while disabled", {15'd0, irq}, 16'd0);
    wr(4'd0, 16'h0001);
    @(negedge clk);
    chk("R10 irq on", {15'd0, irq}, 16'd1);
    chk("R10 wake on", {15'd0, wake}, 16'd1);
    // R9 clear rules
    wr(4'd1, 16'h0000);
    rd(4'd1, v); chk("R9 zero write keeps flag", v, 16'd1);
    wr(4'd1, 16'h0001);
    rd(4'd1, v); chk("R9 one write clears", v, 16'd0);
    chk("R10 irq off after clear", {15'd0, irq}, 16'd0);
    chk("R10 wake off after clear", {15'd0, wake}, 16'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule